// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shift and rotate stage of a processor datapath. One 32-bit operand moves left or right by a count of up to 255. The move is a logical shift, an arithmetic shift, a plain rotate, or a rotate that carries the carry flag along as an extra bit. The unit returns the shifted value, the updated carry flag and a zero flag. The count can come from an instruction immediate or from an 8-bit count register. Operand fetch, writeback and all other flags are handled elsewhere.

The datapath is combinational. A single output register stage holds its result, and that stage loads only when `en` is high. A result therefore appears on the outputs one clock after the cycle in which it was presented with `en` high. Reset is asserted asynchronously and released through a two-flop synchroniser.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is asserted and after it is released, until the first enabled load, `result` reads 0, `carry_out` reads 0 and `zero_out` reads 1.
- R2: Only the low 5 bits of `count` are used. Bits 7:5 have no effect on any output.
- R3: When the low 5 bits of `count` are zero, `result` equals `operand` and `carry_out` equals `carry_in`, for every operation.
- R4: Operation codes 0 (shift left) and 1 (arithmetic shift left) give identical outputs. Zeros fill from the bottom, and `carry_out` is the last bit shifted out of bit 31.
- R5: Operation code 2 (logical shift right) fills zeros from the top, and `carry_out` is the last bit shifted out of bit 0.
- R6: Operation code 3 (arithmetic shift right) copies the original bit 31 into every vacated high position, and `carry_out` is the last bit shifted out of bit 0.
- R7: Operation code 4 (rotate left) loses no bits. For a nonzero count, `carry_out` equals the new bit 0 of the result.
- R8: Operation code 5 (rotate right) loses no bits. For a nonzero count, `carry_out` equals the new bit 31 of the result.
- R9: Operation code 6 (rotate left through carry) rotates the 33-bit value {carry_in, operand} left by the count modulo 33. Each step moves the old carry into bit 0 and the old bit 31 into the carry.
- R10: Operation code 7 (rotate right through carry) rotates {carry_in, operand} right by the count modulo 33. Each step moves the old carry into bit 31 and the old bit 0 into the carry.
- R11: `zero_out` is 1 exactly when `result` is all zeros.
- R12: Outputs update one clock after an enabled cycle. While `en` is low they hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output stage |
| op | input | 3 | Operation code (0..7, see R4 to R10) |
| operand | input | 32 | Value to shift or rotate |
| count | input | 8 | Shift count (low 5 bits used) |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered shifted value |
| carry_out | output | 1 | Registered new carry flag |
| zero_out | output | 1 | Registered zero flag of result |

## Verification
Two functions can meet in one cycle. A masked count of zero overrides the operation; when it coincides with a rotate through carry, the 33-bit path must fall back to the operand and the incoming carry. The bench provokes this with counts such as 32 and 224 on every operation code, among them the rotate-through-carry codes, and it relies on random counts covering the full 8-bit range. A second overlap arises when a result of zero also produces a set carry, as in a single left shift of 0x80000000. Each vector is judged against a bench model that steps the operand one bit at a time, so the comparison covers all three outputs together.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SAL = 3'd1,
    OP_SHR = 3'd2,
    OP_SAR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shr_op_e;
endpackage

// File: rtl/shr_count_norm.sv
module shr_count_norm #(
  parameter int W     = 32,
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(W)
) (
  input  logic [CNT_W-1:0] count,
  output logic [SH_W-1:0]  amt,
  output logic [SH_W:0]    rc_amt,
  output logic             amt_zero
);
  localparam logic [SH_W:0] RC_MOD = (SH_W+1)'(W + 1);

  always_comb begin
    amt      = count[SH_W-1:0];
    amt_zero = (amt == '0);
    rc_amt   = {1'b0, amt} % RC_MOD;
  end
endmodule

// File: rtl/shr_core.sv
module shr_core
  import shr_pkg::*;
#(
  parameter int W     = 32,
  localparam int SH_W = $clog2(W)
) (
  input  shr_op_e         op,
  input  logic [W-1:0]    a,
  input  logic            cin,
  input  logic [SH_W-1:0] amt,
  input  logic [SH_W:0]   rc_amt,
  input  logic            amt_zero,
  output logic [W-1:0]    res,
  output logic            cout
);
  logic [W:0]          shl_ext;
  logic [W:0]          shr_ext;
  logic signed [W:0]   sar_ext;
  logic [2*W-1:0]      rol_dbl;
  logic [2*W-1:0]      ror_dbl;
  logic [W:0]          rc_vec;
  logic [2*W+1:0]      rcl_dbl;
  logic [2*W+1:0]      rcr_dbl;

  always_comb begin
    rc_vec  = {cin, a};
    shl_ext = {1'b0, a} << amt;
    shr_ext = {a, 1'b0} >> amt;
    sar_ext = $signed({a, 1'b0}) >>> amt;
    rol_dbl = {a, a} << amt;
    ror_dbl = {a, a} >> amt;
    rcl_dbl = {rc_vec, rc_vec} << rc_amt;
    rcr_dbl = {rc_vec, rc_vec} >> rc_amt;

    res  = a;
    cout = cin;
    if (!amt_zero) begin
      unique case (op)
        OP_SHL, OP_SAL: begin
          res  = shl_ext[W-1:0];
          cout = shl_ext[W];
        end
        OP_SHR: begin
          res  = shr_ext[W:1];
          cout = shr_ext[0];
        end
        OP_SAR: begin
          res  = sar_ext[W:1];
          cout = sar_ext[0];
        end
        OP_ROL: begin
          res  = rol_dbl[2*W-1:W];
          cout = rol_dbl[W];
        end
        OP_ROR: begin
          res  = ror_dbl[W-1:0];
          cout = ror_dbl[W-1];
        end
        OP_RCL: begin
          res  = rcl_dbl[2*W:W+1];
          cout = rcl_dbl[2*W+1];
        end
        OP_RCR: begin
          res  = rcr_dbl[W-1:0];
          cout = rcr_dbl[W];
        end
        default: begin
          res  = a;
          cout = cin;
        end
      endcase
    end
  end
endmodule

// File: rtl/shr_out_reg.sv
module shr_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_res,
  input  logic         d_cout,
  output logic [W-1:0] q_res,
  output logic         q_cout,
  output logic         q_zero
);
  logic [W-1:0] nxt_res;
  logic         nxt_cout;
  logic         nxt_zero;

  always_comb begin
    nxt_res  = q_res;
    nxt_cout = q_cout;
    nxt_zero = q_zero;
    if (en) begin
      nxt_res  = d_res;
      nxt_cout = d_cout;
      nxt_zero = (d_res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_res  <= '0;
      q_cout <= 1'b0;
      q_zero <= 1'b1;
    end else begin
      q_res  <= nxt_res;
      q_cout <= nxt_cout;
      q_zero <= nxt_zero;
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shr_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       op,
  input  logic [W-1:0]     operand,
  input  logic [CNT_W-1:0] count,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out,
  output logic             zero_out
);
  localparam int SH_W = $clog2(W);

  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [SH_W-1:0] amt;
  logic [SH_W:0]   rc_amt;
  logic            amt_zero;
  logic [W-1:0]    core_res;
  logic            core_cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  shr_count_norm #(.W(W), .CNT_W(CNT_W)) i_norm (
    .count    (count),
    .amt      (amt),
    .rc_amt   (rc_amt),
    .amt_zero (amt_zero)
  );

  shr_core #(.W(W)) i_core (
    .op       (shr_op_e'(op)),
    .a        (operand),
    .cin      (carry_in),
    .amt      (amt),
    .rc_amt   (rc_amt),
    .amt_zero (amt_zero),
    .res      (core_res),
    .cout     (core_cout)
  );

  shr_out_reg #(.W(W)) i_oreg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (en),
    .d_res  (core_res),
    .d_cout (core_cout),
    .q_res  (result),
    .q_cout (carry_out),
    .q_zero (zero_out)
  );
endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [2:0]       op,
  input logic [W-1:0]     operand,
  input logic [CNT_W-1:0] count,
  input logic             carry_in,
  input logic [W-1:0]     result,
  input logic             carry_out,
  input logic             zero_out
);
  localparam int SH_W = $clog2(W);

  logic cnt_nz;
  assign cnt_nz = (count[SH_W-1:0] != '0);

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_nz) |=> (result == $past(operand) && carry_out == $past(carry_in))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(carry_out) && $stable(zero_out))); // R12

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_out == (result == '0)); // R11

  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd4 && cnt_nz) |=> (carry_out == result[0])); // R7

  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd5 && cnt_nz) |=> (carry_out == result[W-1])); // R8

  AST_SAR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd3) |=> (result[W-1] == $past(operand[W-1]))); // R6

  AST_SHL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[2:1] == 2'b00 && cnt_nz) |=> (result[0] == 1'b0)); // R4

  AST_SHR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd2 && cnt_nz) |=> (result[W-1] == 1'b0)); // R5
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.W(W), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .op        (op),
  .operand   (operand),
  .count     (count),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .zero_out  (zero_out)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [2:0]  op;
  logic [31:0] operand;
  logic [7:0]  count;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;
  logic        zero_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shift_rotate_unit i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .operand(operand),
    .count(count), .carry_in(carry_in), .result(result),
    .carry_out(carry_out), .zero_out(zero_out)
  );

  // Bit-serial reference: returns {zero, carry, result}
  function automatic logic [33:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [7:0] cnt, input logic c);
    logic [31:0] r = a;
    logic        cy = c;
    logic        t;
    int          n = int'(cnt[4:0]);
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd0, 3'd1: begin cy = r[31]; r = {r[30:0], 1'b0}; end
        3'd2:       begin cy = r[0];  r = {1'b0, r[31:1]}; end
        3'd3:       begin cy = r[0];  r = {r[31], r[31:1]}; end
        3'd4:       begin r = {r[30:0], r[31]}; cy = r[0]; end
        3'd5:       begin r = {r[0], r[31:1]};  cy = r[31]; end
        3'd6:       begin t = r[31]; r = {r[30:0], cy}; cy = t; end
        default:    begin t = r[0];  r = {cy, r[31:1]}; cy = t; end
      endcase
    end
    return {(r == 32'd0), cy, r};
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R4";
      3'd2:       return "R5";
      3'd3:       return "R6";
      3'd4:       return "R7";
      3'd5:       return "R8";
      3'd6:       return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [33:0] exp);
    logic [33:0] act = {zero_out, carry_out, result};
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual z=%b c=%b r=%h expected z=%b c=%b r=%h",
               req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // Drive at negedge, load at posedge, check at next negedge
  task automatic apply(input logic [2:0] o, input logic [31:0] a,
                       input logic [7:0] cnt, input logic c, input string req);
    op = o; operand = a; count = cnt; carry_in = c; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(req, model(o, a, cnt, c));
  endtask

  initial begin
    logic [33:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; op = '0; operand = '0; count = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {1'b1, 1'b0, 32'd0});          // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {1'b1, 1'b0, 32'd0});          // R1 after release

    // R3 / R2: masked count of zero on every op (32 and 224 mask to 0)
    for (int o = 0; o < 8; o++) begin
      apply(3'(o), 32'hDEAD_BEEF, 8'd32, 1'b1, "R3");
      apply(3'(o), 32'h1234_5678, 8'd224, 1'b0, "R2");
    end
    // R2: upper count bits ignored (0x21 acts as 1)
    apply(3'd0, 32'h8000_0001, 8'h21, 1'b0, "R2");
    apply(3'd6, 32'h0000_0001, 8'hE3, 1'b1, "R2");
    // R4: SHL and SAL, carry from bit 31, result zero -> R11 too
    apply(3'd0, 32'h8000_0000, 8'd1, 1'b0, "R4");
    apply(3'd1, 32'h8000_0000, 8'd1, 1'b0, "R11");
    apply(3'd1, 32'h0F0F_1234, 8'd31, 1'b1, "R4");
    // R5 / R6
    apply(3'd2, 32'hFFFF_FFFF, 8'd31, 1'b0, "R5");
    apply(3'd3, 32'h8000_0000, 8'd31, 1'b0, "R6");
    apply(3'd3, 32'h7FFF_FFFE, 8'd4, 1'b1, "R6");
    // R7 / R8
    apply(3'd4, 32'h8000_0001, 8'd1, 1'b0, "R7");
    apply(3'd5, 32'h0000_0001, 8'd1, 1'b0, "R8");
    // R9 / R10 boundary counts
    apply(3'd6, 32'h8000_0000, 8'd1, 1'b0, "R9");
    apply(3'd6, 32'h0000_0001, 8'd31, 1'b1, "R9");
    apply(3'd7, 32'h0000_0001, 8'd1, 1'b0, "R10");
    apply(3'd7, 32'h8000_0000, 8'd31, 1'b1, "R10");
    // R11: zero result
    apply(3'd2, 32'h0000_0001, 8'd1, 1'b1, "R11");

    // R12: enable low holds outputs
    apply(3'd4, 32'hA5A5_0F0F, 8'd5, 1'b0, "R12");
    held = model(3'd4, 32'hA5A5_0F0F, 8'd5, 1'b0);
    en = 1'b0; op = 3'd2; operand = 32'hFFFF_FFFF; count = 8'd3; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", held);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  ro = 3'($urandom_range(0, 7));
      logic [31:0] ra = $urandom();
      logic [7:0]  rc = 8'($urandom());
      logic        rb = 1'($urandom());
      if (i % 7 == 0) ra = 32'd0;
      apply(ro, ra, rc, rb, req_of(ro));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule